// File: doc/BRIEF.md
# Unlock-Gated Option Memory Remapper

This block sits next to the program-memory read path of a small processor core. It watches byte writes to an 8-bit control register. When the unlock pair (0x55, then 0xAA) lands in two back-to-back instruction cycles, the block opens a remap window for a limited time. While that window is open, table reads that fall in the top 32 word locations of the last program page are served from a separate 32-word option memory. All other reads are served from the main array.

The window closes by itself when a slow free-running clock shows its fourth rising edge after the unlock. The slow clock is synchronised inside the block. Writing a fresh unlock pair while the window is open starts the count again from zero. A wake-from-standby pulse clears the control register, drops any partial unlock and closes the window.

The table address is built from an 8-bit low pointer and a page pointer. A "last page" form of the read ignores the page pointer and forces the last page. The returned word is presented as a high part, for the holding register, and a low byte, for the instruction's destination.

Top module: `omr_remap`

## Requirements
- R1: After reset the control register reads 0x00 and the window flag is low.
- R2: A write (`ctl_wr` high in a cycle with `cyc_en` high) loads `ctl_wdata` into the control register, and `ctl_rdata` shows it from the next cycle. A write strobe in a cycle with `cyc_en` low changes nothing.
- R3: A write of 0x55 in one instruction cycle, followed by a write of 0xAA in the next instruction cycle, raises `win_open` in the cycle after the 0xAA write. Clock cycles with `cyc_en` low are not instruction cycles and do not break the pair.
- R4: The window does not open for any other data, for the reverse order, or when an instruction cycle without a write comes between the two bytes.
- R5: A 0x55 written right after another 0x55 counts as a new first byte, so 0x55, 0x55, 0xAA opens the window.
- R6: Once open, the window closes on the fourth synchronised rising edge of `slow_clk`. `win_open` is low three clock edges after `slow_clk` rises for the fourth time (two synchroniser stages plus the edge register).
- R7: A further valid unlock pair while the window is open restarts the count, so four more slow rising edges are needed to close it.
- R8: `wake_clr` clears the control register to 0x00, closes the window, and drops a pending first byte.
- R9: With the window open, a read whose page is all ones and whose low byte is 0xE0 to 0xFF returns `opt_word`. `opt_idx` always equals the low 5 bits of the low pointer.
- R10: In every other case, whether the window is closed, the page is not the last page, or the low byte is 0x00 to 0xDF, the read returns `main_word` unchanged.
- R11: `main_addr` is {page, `ptr_lo`}. The page is all ones when `rd_last_pg` is 1, and `ptr_hi` when it is 0.
- R12: `rd_hi` carries the upper bits of the selected word (bits 15 to 8 by default), and `rd_lo` carries bits 7 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wake_clr | input | 1 | Pulse on wake from standby |
| cyc_en | input | 1 | Instruction-cycle enable |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| slow_clk | input | 1 | Asynchronous slow clock |
| ptr_lo | input | 8 | Table pointer, low byte |
| ptr_hi | input | PG_W | Table pointer, page |
| rd_last_pg | input | 1 | Read uses the last page regardless of ptr_hi |
| main_addr | output | PG_W+8 | Address to main program memory |
| opt_idx | output | 5 | Address to option memory |
| main_word | input | WORD_W | Main memory read data |
| opt_word | input | WORD_W | Option memory read data |
| rd_hi | output | WORD_W-8 | Selected word, high part |
| rd_lo | output | 8 | Selected word, low byte |
| win_open | output | 1 | Remap window active |

## Verification
The hardest situation to reach from the ports is the re-armed timeout. The window must have absorbed some slow edges, then take a second unlock pair, and then survive more than four total slow edges before it closes. The directed part of the bench counts slow pulses one at a time around such a re-unlock. Long random runs of mixed 0x55/0xAA/other bytes, with idle instruction cycles, disabled cycles and wake pulses, work through the arming corner cases against a bench model of the sequence detector.

// File: rtl/omr_pkg.sv
package omr_pkg;
   localparam logic [7:0] KEY_FIRST  = 8'h55;
   localparam logic [7:0] KEY_SECOND = 8'hAA;
   localparam int unsigned LOW_W = 8;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/omr_unlock.sv
module omr_unlock
   import omr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wake_clr,
   input  logic       cyc_en,
   input  logic       wr,
   input  logic [7:0] wdata,
   output logic [7:0] ctl_q,
   output logic       armed_q,
   output logic       unlock_hit
);
   logic wr_eff;
   assign wr_eff = cyc_en && wr;

   // second byte completes the pair only if the previous instruction cycle armed
   assign unlock_hit = wr_eff && (wdata == KEY_SECOND) && armed_q && !wake_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= 8'h00;
         armed_q <= 1'b0;
      end else if (wake_clr) begin
         ctl_q   <= 8'h00;
         armed_q <= 1'b0;
      end else if (cyc_en) begin
         if (wr) ctl_q <= wdata;
         // any instruction cycle re-evaluates arming; repeated 0x55 re-arms
         armed_q <= wr && (wdata == KEY_FIRST);
      end
   end
endmodule

// File: rtl/omr_timer.sv
module omr_timer #(
   parameter int unsigned TICKS       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wake_clr,
   input  logic restart,
   input  logic slow_in,
   output logic active
);
   localparam int unsigned CNT_W = (TICKS > 2) ? $clog2(TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

   if (TICKS < 2)       begin : g_bad_ticks $error("TICKS must be at least 2"); end
   if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end

   logic [SYNC_STAGES-1:0] stage;
   logic                   prev_q;
   logic                   rise;
   logic [CNT_W-1:0]       cnt_q;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage[0] <= 1'b0;
            else        stage[0] <= slow_in;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage[g] <= 1'b0;
            else        stage[g] <= stage[g-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= stage[SYNC_STAGES-1];

   assign rise = stage[SYNC_STAGES-1] && !prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt_q  <= '0;
      end else if (wake_clr) begin
         active <= 1'b0;
         cnt_q  <= '0;
      end else if (restart) begin
         active <= 1'b1;
         cnt_q  <= '0;
      end else if (active && rise) begin
         if (cnt_q == LAST) begin
            active <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/omr_steer.sv
module omr_steer
   import omr_pkg::*;
#(
   parameter int unsigned PG_W      = 4,
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned OPT_DEPTH = 32
) (
   input  logic                      win_open,
   input  logic                      rd_last_pg,
   input  logic [LOW_W-1:0]          ptr_lo,
   input  logic [PG_W-1:0]           ptr_hi,
   input  logic [WORD_W-1:0]         main_word,
   input  logic [WORD_W-1:0]         opt_word,
   output logic [PG_W+LOW_W-1:0]     main_addr,
   output logic [$clog2(OPT_DEPTH)-1:0] opt_idx,
   output logic [WORD_W-LOW_W-1:0]   rd_hi,
   output logic [LOW_W-1:0]          rd_lo
);
   localparam int unsigned IDX_W = $clog2(OPT_DEPTH);

   if (!is_pow2(OPT_DEPTH) || OPT_DEPTH < 2 || OPT_DEPTH > 128) begin : g_bad_depth
      $error("OPT_DEPTH must be a power of two in 2..128");
   end
   if (WORD_W <= LOW_W) begin : g_bad_word
      $error("WORD_W must exceed the low byte width");
   end
   if (PG_W < 1) begin : g_bad_pg
      $error("PG_W must be at least 1");
   end

   logic [PG_W-1:0]   page;
   logic              top_slice;
   logic              last_page;
   logic [WORD_W-1:0] sel_word;

   assign page      = rd_last_pg ? {PG_W{1'b1}} : ptr_hi;
   assign main_addr = {page, ptr_lo};
   assign last_page = &page;
   assign top_slice = &ptr_lo[LOW_W-1:IDX_W];
   assign opt_idx   = ptr_lo[IDX_W-1:0];

   assign sel_word = (win_open && last_page && top_slice) ? opt_word : main_word;
   assign rd_hi    = sel_word[WORD_W-1:LOW_W];
   assign rd_lo    = sel_word[LOW_W-1:0];
endmodule

// File: rtl/omr_remap.sv
module omr_remap #(
   parameter int unsigned PG_W        = 4,
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned OPT_DEPTH   = 32,
   parameter int unsigned TICKS       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wake_clr,
   input  logic                         cyc_en,
   input  logic                         ctl_wr,
   input  logic [7:0]                   ctl_wdata,
   output logic [7:0]                   ctl_rdata,
   input  logic                         slow_clk,
   input  logic [7:0]                   ptr_lo,
   input  logic [PG_W-1:0]              ptr_hi,
   input  logic                         rd_last_pg,
   output logic [PG_W+7:0]              main_addr,
   output logic [$clog2(OPT_DEPTH)-1:0] opt_idx,
   input  logic [WORD_W-1:0]            main_word,
   input  logic [WORD_W-1:0]            opt_word,
   output logic [WORD_W-9:0]            rd_hi,
   output logic [7:0]                   rd_lo,
   output logic                         win_open
);
   logic armed;
   logic unlock_hit;

   omr_unlock u_unlock (
      .clk        (clk),
      .rst_n      (rst_n),
      .wake_clr   (wake_clr),
      .cyc_en     (cyc_en),
      .wr         (ctl_wr),
      .wdata      (ctl_wdata),
      .ctl_q      (ctl_rdata),
      .armed_q    (armed),
      .unlock_hit (unlock_hit)
   );

   omr_timer #(.TICKS(TICKS), .SYNC_STAGES(SYNC_STAGES)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .wake_clr (wake_clr),
      .restart  (unlock_hit),
      .slow_in  (slow_clk),
      .active   (win_open)
   );

   omr_steer #(.PG_W(PG_W), .WORD_W(WORD_W), .OPT_DEPTH(OPT_DEPTH)) u_steer (
      .win_open   (win_open),
      .rd_last_pg (rd_last_pg),
      .ptr_lo     (ptr_lo),
      .ptr_hi     (ptr_hi),
      .main_word  (main_word),
      .opt_word   (opt_word),
      .main_addr  (main_addr),
      .opt_idx    (opt_idx),
      .rd_hi      (rd_hi),
      .rd_lo      (rd_lo)
   );
endmodule

// File: rtl/omr_remap_chk.sv
module omr_remap_chk #(
   parameter int unsigned PG_W      = 4,
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned OPT_DEPTH = 32
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         wake_clr,
   input logic                         cyc_en,
   input logic                         ctl_wr,
   input logic [7:0]                   ctl_wdata,
   input logic [7:0]                   ctl_rdata,
   input logic                         unlock_hit,
   input logic                         rd_last_pg,
   input logic [PG_W+7:0]              main_addr,
   input logic [$clog2(OPT_DEPTH)-1:0] opt_idx,
   input logic [WORD_W-1:0]            main_word,
   input logic [WORD_W-1:0]            opt_word,
   input logic [WORD_W-9:0]            rd_hi,
   input logic [7:0]                   rd_lo,
   input logic                         win_open
);
   localparam int unsigned IDX_W = $clog2(OPT_DEPTH);

   a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_en && ctl_wr && !wake_clr) |=> (ctl_rdata == $past(ctl_wdata)));

   a_r3_pair_opens: assert property (@(posedge clk) disable iff (!rst_n)
      unlock_hit |=> win_open);

   a_r4_open_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_open) |-> $past(unlock_hit));

   a_r8_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wake_clr |=> (!win_open && ctl_rdata == 8'h00));

   a_r9_option_data: assert property (@(posedge clk) disable iff (!rst_n)
      (win_open && (&main_addr[PG_W+7:8]) && (&main_addr[7:IDX_W]))
         |-> ({rd_hi, rd_lo} == opt_word));

   a_r9_index: assert property (@(posedge clk) disable iff (!rst_n)
      opt_idx == main_addr[IDX_W-1:0]);

   a_r10_closed_main: assert property (@(posedge clk) disable iff (!rst_n)
      !win_open |-> ({rd_hi, rd_lo} == main_word));

   a_r11_last_page: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last_pg |-> (&main_addr[PG_W+7:8]));
endmodule

bind omr_remap omr_remap_chk #(.PG_W(PG_W), .WORD_W(WORD_W), .OPT_DEPTH(OPT_DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wake_clr   (wake_clr),
   .cyc_en     (cyc_en),
   .ctl_wr     (ctl_wr),
   .ctl_wdata  (ctl_wdata),
   .ctl_rdata  (ctl_rdata),
   .unlock_hit (unlock_hit),
   .rd_last_pg (rd_last_pg),
   .main_addr  (main_addr),
   .opt_idx    (opt_idx),
   .main_word  (main_word),
   .opt_word   (opt_word),
   .rd_hi      (rd_hi),
   .rd_lo      (rd_lo),
   .win_open   (win_open)
);

// File: tb/omr_remap_tb.sv
module omr_remap_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wake_clr = 1'b0;
   logic        cyc_en = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [7:0]  ctl_wdata = 8'h00;
   logic [7:0]  ctl_rdata;
   logic        slow_clk = 1'b0;
   logic [7:0]  ptr_lo = 8'h00;
   logic [3:0]  ptr_hi = 4'h0;
   logic        rd_last_pg = 1'b0;
   logic [11:0] main_addr;
   logic [4:0]  opt_idx;
   logic [15:0] main_word = 16'h0;
   logic [15:0] opt_word = 16'h0;
   logic [7:0]  rd_hi;
   logic [7:0]  rd_lo;
   logic        win_open;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   omr_remap u_dut (
      .clk(clk), .rst_n(rst_n), .wake_clr(wake_clr), .cyc_en(cyc_en),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .slow_clk(slow_clk), .ptr_lo(ptr_lo), .ptr_hi(ptr_hi),
      .rd_last_pg(rd_last_pg), .main_addr(main_addr), .opt_idx(opt_idx),
      .main_word(main_word), .opt_word(opt_word), .rd_hi(rd_hi),
      .rd_lo(rd_lo), .win_open(win_open)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] f_word(bit open, bit last, logic [3:0] hi,
                                          logic [7:0] lo, logic [15:0] m, logic [15:0] o);
      logic [3:0] pg;
      pg = last ? 4'hF : hi;
      return (open && pg == 4'hF && lo >= 8'hE0) ? o : m;
   endfunction

   // one clock of stimulus: drive at negedge, the edge consumes it
   task automatic step(input bit en, input bit wr, input logic [7:0] d);
      @(negedge clk);
      cyc_en = en; ctl_wr = wr; ctl_wdata = d; wake_clr = 1'b0;
      @(posedge clk);
   endtask

   task automatic idle_sample;
      @(negedge clk);
      cyc_en = 1'b0; ctl_wr = 1'b0; wake_clr = 1'b0;
      #2;
   endtask

   task automatic wake;
      @(negedge clk);
      cyc_en = 1'b0; ctl_wr = 1'b0; wake_clr = 1'b1;
      @(posedge clk);
      idle_sample();
   endtask

   // one slow rising edge, fully propagated through the synchroniser
   task automatic slow_pulse;
      @(negedge clk); slow_clk = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); slow_clk = 1'b0;
      repeat (3) @(posedge clk);
      idle_sample();
   endtask

   task automatic unlock;
      step(1, 1, 8'h55);
      step(1, 1, 8'hAA);
      idle_sample();
   endtask

   task automatic read_chk(input string req, input bit last, input logic [3:0] hi,
                           input logic [7:0] lo);
      logic [15:0] m, o;
      m = 16'($urandom); o = 16'($urandom);
      if (o == m) o = ~m;
      rd_last_pg = last; ptr_hi = hi; ptr_lo = lo; main_word = m; opt_word = o;
      #1;
      chk(req, {rd_hi, rd_lo}, f_word(win_open, last, hi, lo, m, o));
      chk("R11 addr", main_addr, {(last ? 4'hF : hi), lo});
      chk("R9 idx", opt_idx, lo[4:0]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      bit exp_open, exp_armed;
      logic [7:0] exp_ctl;
      void'($urandom(32'h5EED1234));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #2;
      chk("R1 ctl reset", ctl_rdata, 8'h00);
      chk("R1 win reset", win_open, 1'b0);

      // R2: write loads, disabled-cycle strobe ignored
      step(1, 1, 8'h3C); idle_sample();
      chk("R2 write", ctl_rdata, 8'h3C);
      step(0, 1, 8'hC3); idle_sample();
      chk("R2 disabled write", ctl_rdata, 8'h3C);

      // R3 basic
      unlock();
      chk("R3 opened", win_open, 1'b1);
      read_chk("R9 opt hit E0", 1, 4'h2, 8'hE0);
      read_chk("R9 opt hit FF", 0, 4'hF, 8'hFF);
      read_chk("R10 below DF", 1, 4'h0, 8'hDF);
      read_chk("R10 other page", 0, 4'h7, 8'hF3);
      read_chk("R12 split", 1, 4'h0, 8'hEA);
      wake();
      chk("R8 closed", win_open, 1'b0);
      chk("R8 ctl cleared", ctl_rdata, 8'h00);
      read_chk("R10 closed", 1, 4'h0, 8'hF0);

      // R3 with disabled cycles inside the pair
      step(1, 1, 8'h55); step(0, 0, 8'h00); step(0, 1, 8'h77); step(1, 1, 8'hAA);
      idle_sample();
      chk("R3 gap of disabled cycles", win_open, 1'b1);
      chk("R2 disabled write in gap", ctl_rdata, 8'hAA);
      wake();

      // R4 negatives
      step(1, 1, 8'h55); step(1, 0, 8'h00); step(1, 1, 8'hAA); idle_sample();
      chk("R4 idle instr cycle", win_open, 1'b0);
      step(1, 1, 8'hAA); step(1, 1, 8'h55); idle_sample();
      chk("R4 reverse", win_open, 1'b0);
      step(1, 1, 8'h55); step(1, 1, 8'hAB); step(1, 1, 8'hAA); idle_sample();
      chk("R4 wrong byte", win_open, 1'b0);

      // R5
      step(1, 1, 8'h55); step(1, 1, 8'h55); step(1, 1, 8'hAA); idle_sample();
      chk("R5 repeated first", win_open, 1'b1);
      wake();

      // R8 drops pending first byte
      step(1, 1, 8'h55); wake(); step(1, 1, 8'hAA); idle_sample();
      chk("R8 arming dropped", win_open, 1'b0);

      // R6
      unlock();
      for (int i = 1; i <= 3; i++) begin
         slow_pulse();
         chk("R6 still open", win_open, 1'b1);
      end
      slow_pulse();
      chk("R6 closed on 4th", win_open, 1'b0);

      // R7 restart
      unlock();
      slow_pulse(); slow_pulse(); slow_pulse();
      unlock();
      chk("R7 reopened", win_open, 1'b1);
      for (int i = 1; i <= 3; i++) begin
         slow_pulse();
         chk("R7 open after restart", win_open, 1'b1);
      end
      slow_pulse();
      chk("R7 closed after 4 more", win_open, 1'b0);
      wake();

      // random sequence phase against a bench model
      exp_open = 0; exp_armed = 0; exp_ctl = 8'h00;
      for (int n = 0; n < 600; n++) begin
         logic [31:0] r;
         logic [7:0]  d;
         bit en, wr, wk;
         @(negedge clk);
         #2;
         chk("R3 R4 R5 random window", win_open, exp_open);
         chk("R2 R8 random ctl", ctl_rdata, exp_ctl);
         r  = $urandom;
         wk = (r[4:0] == 5'd0);
         en = (r[6:5] != 2'd0);
         wr = (r[8:7] != 2'd0);
         case (r[10:9])
            2'd0, 2'd1: d = 8'h55;
            2'd2:       d = 8'hAA;
            default:    d = 8'($urandom);
         endcase
         read_chk("R9 R10 random read", r[11], 4'($urandom), {r[12] ? 3'b111 : 3'($urandom), 5'($urandom)});
         wake_clr = wk; cyc_en = en; ctl_wr = wr; ctl_wdata = d;
         if (wk) begin
            exp_open = 0; exp_armed = 0; exp_ctl = 8'h00;
         end else if (en) begin
            if (wr) exp_ctl = d;
            if (wr && d == 8'hAA && exp_armed) exp_open = 1;
            exp_armed = wr && d == 8'h55;
         end
      end
      idle_sample();
      chk("R3 random final", win_open, exp_open);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule